// File: doc/BRIEF.md
# Sequential Floating-Point Adder/Subtracter

This unit adds or subtracts two single-precision binary floating-point words (1 sign bit, 8-bit biased exponent, 23-bit fraction) over several clock cycles. Rather than using wide barrel shifters, it aligns and normalises one bit position per clock. Each operand mantissa sits in its own right-shift register, paired with an exponent counter. The sum or difference goes into a result register that can shift in either direction, paired with its own exponent counter. An equality/ordering comparator on the two exponents steers the sequencing.

A host pulses `start` with both operands and the operation bit present. The unit captures them and works through its states. It then raises `done` for one cycle, with the answer on `result`, and holds that answer until the next operation completes.

The controller has six states:

- IDLE: waits for `start`, then goes to CHECK.
- CHECK: if either operand is zero, it goes straight to DONE. Otherwise it goes to ALIGN.
- ALIGN: repeats while the exponents differ. It leaves for ARITH when the exponents are equal, or when the gap is too wide.
- ARITH: goes to DONE when the magnitude is zero. Otherwise it goes to NORM.
- NORM: repeats while shifting. It goes to DONE when the result is normalised, overflows or underflows.
- DONE: returns to IDLE.

Top module: `fp_addsub_seq`

## Requirements
- R1: With `sub_op`=0 the result is A+B. With `sub_op`=1 it is A−B, computed by inverting the sign of B. Equal effective signs add magnitudes, and unequal ones subtract them.
- R2: An operand whose exponent field is 0 is taken as zero, and its fraction is ignored.
  - If only A is zero, the result is B (sign inverted when subtracting).
  - If only B is zero, the result is A.
  - If both are zero, the result is +0 (0x00000000).
- R3: During alignment, the operand with the smaller exponent shifts right one bit per cycle while its exponent counts up. Bits shifted out are discarded, so 1.0 + 2^-24 gives 1.0 and 1.0 + 2^-23 gives 0x3F800001.
- R4: When the exponents differ by more than 25, the smaller operand is treated as zero. The result then equals the larger operand, with its effective sign.
- R5: For an effective subtraction, the smaller aligned magnitude is taken from the larger, and the result carries the sign of the larger. An exactly zero difference returns +0.
- R6: A carry out of the sum shifts the result right once and increments its exponent. Otherwise the result shifts left, decrementing the exponent, until the hidden bit (bit 23 of the significand) is 1.
- R7: If the exponent would reach 255, the result is infinity: exponent field 0xFF, fraction 0, with the result sign.
- R8: A result that would need an exponent below 1 is returned as +0.
- R9: `start` is accepted only in IDLE and is ignored while an operation runs. `done` is a one-cycle pulse. `result` changes only in the cycle `done` is high.
- R10: During reset, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| sub_op | input | 1 | 0 = add, 1 = subtract B from A |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Sum or difference, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle. These are the single-cycle shape of `done`, the stability of `result` outside completion cycles, and the absence of negative zero, NaN-shaped infinities and denormal patterns in any result. Arithmetic correctness needs the bench's scenarios. These cover the alignment gap, the boundary at 25, the truncation of shifted-out bits, the sign choice in subtraction, overflow, underflow flushing, the zero bypass and a `start` issued mid-operation.

// File: rtl/fpas_pkg.sv
`timescale 1ns/1ps
package fpas_pkg;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ALIGN,
        ST_ARITH,
        ST_NORM,
        ST_DONE
    } fsm_t;
endpackage

// File: rtl/fpas_man_sreg.sv
`timescale 1ns/1ps
// Operand significand register: parallel load, clear, shift right by one.
module fpas_man_sreg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr,
    input  logic         shr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= din;
        else if (clr)   q <= '0;
        else if (shr)   q <= q >> 1;
    end
endmodule

// File: rtl/fpas_exp_cnt.sv
`timescale 1ns/1ps
// Exponent register with load and single-step up/down counting.
module fpas_exp_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    input  logic         dec,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= din;
        else if (inc)   q <= q + 1'b1;
        else if (dec)   q <= q - 1'b1;
    end
endmodule

// File: rtl/fpas_res_sreg.sv
`timescale 1ns/1ps
// Result significand register with carry bit: load, shift left or right.
module fpas_res_sreg #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         dir_left,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= din;
        else if (shift) q <= dir_left ? (q << 1) : (q >> 1);
    end
endmodule

// File: rtl/fp_addsub_seq.sv
`timescale 1ns/1ps
module fp_addsub_seq
    import fpas_pkg::*;
#(
    parameter int EXP_W = fpas_pkg::EXP_W,
    parameter int MAN_W = fpas_pkg::MAN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   sub_op,
    input  logic [EXP_W+MAN_W:0]   opnd_a,
    input  logic [EXP_W+MAN_W:0]   opnd_b,
    output logic [EXP_W+MAN_W:0]   result,
    output logic                   done
);
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int SIG_W  = MAN_W + 1;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_MAX - 1'b1;
    localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(1);
    localparam logic [EXP_W-1:0] FAR_LIM = EXP_W'(SIG_W + 1);

    fsm_t state_q, state_d;

    logic [WORD_W-1:0] in_word [2];
    logic [SIG_W-1:0]  man_q   [2];
    logic [EXP_W-1:0]  exp_q   [2];
    logic [1:0]        zero_op, clr_man, shr_man;
    logic              ld_op, ld_res, ld_word, norm_r, norm_l;
    logic              sgn_a_q, sgn_b_q, res_sgn_q;
    logic [SIG_W:0]    res_q, sum_d;
    logic [EXP_W-1:0]  res_exp_q, exp_diff;
    logic              exp_gt, exp_lt, exp_eq, far, eff_sub, a_ge;
    logic [WORD_W-1:0] word_d, bypass_word, result_q;

    assign in_word[0] = opnd_a;
    assign in_word[1] = opnd_b;

    for (genvar i = 0; i < 2; i++) begin : g_opnd
        fpas_man_sreg #(.W(SIG_W)) u_man (
            .clk(clk), .rst_n(rst_n), .load(ld_op), .clr(clr_man[i]), .shr(shr_man[i]),
            .din({|in_word[i][WORD_W-2:MAN_W], in_word[i][MAN_W-1:0]}),
            .q(man_q[i])
        );
        fpas_exp_cnt #(.W(EXP_W)) u_exp (
            .clk(clk), .rst_n(rst_n), .load(ld_op), .inc(shr_man[i]), .dec(1'b0),
            .din(in_word[i][WORD_W-2:MAN_W]),
            .q(exp_q[i])
        );
        assign zero_op[i] = (exp_q[i] == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_a_q <= 1'b0;
            sgn_b_q <= 1'b0;
        end else if (ld_op) begin
            sgn_a_q <= opnd_a[WORD_W-1];
            sgn_b_q <= opnd_b[WORD_W-1] ^ sub_op;
        end
    end

    // Exponent comparator and alignment distance
    assign exp_gt   = exp_q[0] > exp_q[1];
    assign exp_lt   = exp_q[0] < exp_q[1];
    assign exp_eq   = exp_q[0] == exp_q[1];
    assign exp_diff = exp_gt ? (exp_q[0] - exp_q[1]) : (exp_q[1] - exp_q[0]);
    assign far      = exp_diff > FAR_LIM;

    // Significand adder/subtracter, larger magnitude first
    assign eff_sub = sgn_a_q ^ sgn_b_q;
    assign a_ge    = man_q[0] >= man_q[1];
    always_comb begin
        if (!eff_sub)  sum_d = {1'b0, man_q[0]} + {1'b0, man_q[1]};
        else if (a_ge) sum_d = {1'b0, man_q[0]} - {1'b0, man_q[1]};
        else           sum_d = {1'b0, man_q[1]} - {1'b0, man_q[0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      res_sgn_q <= 1'b0;
        else if (ld_res) res_sgn_q <= (eff_sub && !a_ge) ? sgn_b_q : sgn_a_q;
    end

    fpas_exp_cnt #(.W(EXP_W)) u_res_exp (
        .clk(clk), .rst_n(rst_n), .load(ld_res), .inc(norm_r), .dec(norm_l),
        .din(exp_lt ? exp_q[1] : exp_q[0]),
        .q(res_exp_q)
    );

    fpas_res_sreg #(.W(SIG_W + 1)) u_res (
        .clk(clk), .rst_n(rst_n), .load(ld_res), .shift(norm_r | norm_l),
        .dir_left(norm_l), .din(sum_d), .q(res_q)
    );

    always_comb begin
        if (zero_op[0] && zero_op[1]) bypass_word = '0;
        else if (zero_op[0])          bypass_word = {sgn_b_q, exp_q[1], man_q[1][MAN_W-1:0]};
        else                          bypass_word = {sgn_a_q, exp_q[0], man_q[0][MAN_W-1:0]};
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath controls
    always_comb begin
        state_d = state_q;
        ld_op   = 1'b0;
        ld_res  = 1'b0;
        ld_word = 1'b0;
        norm_r  = 1'b0;
        norm_l  = 1'b0;
        clr_man = '0;
        shr_man = '0;
        word_d  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ld_op   = 1'b1;
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (|zero_op) begin
                    ld_word = 1'b1;
                    word_d  = bypass_word;
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                if (exp_eq) begin
                    state_d = ST_ARITH;
                end else if (far) begin
                    clr_man[exp_gt] = 1'b1;
                    state_d = ST_ARITH;
                end else begin
                    shr_man[exp_gt] = 1'b1;
                end
            end
            ST_ARITH: begin
                if (sum_d == '0) begin
                    ld_word = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    ld_res  = 1'b1;
                    state_d = ST_NORM;
                end
            end
            ST_NORM: begin
                if (res_q[SIG_W]) begin
                    if (res_exp_q == EXP_TOP) begin
                        ld_word = 1'b1;
                        word_d  = {res_sgn_q, EXP_MAX, {MAN_W{1'b0}}};
                        state_d = ST_DONE;
                    end else begin
                        norm_r = 1'b1;
                    end
                end else if (res_q[SIG_W-1]) begin
                    ld_word = 1'b1;
                    word_d  = {res_sgn_q, res_exp_q, res_q[MAN_W-1:0]};
                    state_d = ST_DONE;
                end else if (res_exp_q == EXP_ONE) begin
                    ld_word = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    norm_l = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       result_q <= '0;
        else if (ld_word) result_q <= word_d;
    end

    assign result = result_q;
    assign done   = (state_q == ST_DONE);
endmodule

// File: rtl/fpas_chk.sv
`timescale 1ns/1ps
module fpas_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic [EXP_W+MAN_W:0] result
);
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the result only moves in a completion cycle
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R7: an all-ones exponent always carries a zero fraction
    assert_inf_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[WORD_W-2:MAN_W] == '1)) |-> (result[MAN_W-1:0] == '0));

    // R5: a zero result is never negative
    assert_zero_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[WORD_W-2:0] == '0)) |-> !result[WORD_W-1]);

    // R8: no denormal bit pattern is produced
    assert_no_denorm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[WORD_W-2:MAN_W] == '0)) |-> (result[MAN_W-1:0] == '0));
endmodule

bind fp_addsub_seq fpas_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .done(done),
    .result(result)
);

// File: tb/fp_addsub_seq_tb_top.sv
`timescale 1ns/1ps
module fp_addsub_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sub_op = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        done;

    int n_checks = 0;
    int n_err = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fp_addsub_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_op(sub_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done)
    );

    // {a, b, sub_op, expected, requirement number}
    localparam int NVEC = 21;
    localparam logic [100:0] VEC [NVEC] = '{
        {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 4'd1}, // R1 1+1
        {32'h40000000, 32'h3F800000, 1'b0, 32'h40400000, 4'd1}, // R1 2+1
        {32'h3FC00000, 32'h3E800000, 1'b0, 32'h3FE00000, 4'd3}, // R3 1.5+0.25
        {32'hC0000000, 32'hC0400000, 1'b0, 32'hC0A00000, 4'd6}, // R6 -2+-3 carry
        {32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 4'd1}, // R1 1-(-1)
        {32'h40400000, 32'h3FC00000, 1'b1, 32'h3FC00000, 4'd5}, // R5 3-1.5
        {32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, 4'd5}, // R5 1-2
        {32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'd5}, // R5 1-1 -> +0
        {32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 4'd6}, // R6 many left shifts
        {32'h00000000, 32'h40A00000, 1'b0, 32'h40A00000, 4'd2}, // R2 0+5
        {32'h00000000, 32'h40A00000, 1'b1, 32'hC0A00000, 4'd2}, // R2 0-5
        {32'h40A00000, 32'h00000000, 1'b1, 32'h40A00000, 4'd2}, // R2 5-0
        {32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 4'd2}, // R2 -0+-0
        {32'h007FFFFF, 32'h3F800000, 1'b0, 32'h3F800000, 4'd2}, // R2 denormal as zero
        {32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 4'd4}, // R4 gap 30
        {32'h30800000, 32'h40A00000, 1'b1, 32'hC0A00000, 4'd4}, // R4 A smaller
        {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 4'd3}, // R3 gap 24 lost
        {32'h3F800000, 32'h34000000, 1'b0, 32'h3F800001, 4'd3}, // R3 gap 23 kept
        {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'd7}, // R7 +inf
        {32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 4'd7}, // R7 -inf
        {32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 4'd8}  // R8 flush
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic op);
        @(negedge clk);
        opnd_a = a;
        opnd_b = b;
        sub_op = op;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] got);
        got = 'x;
        for (int k = 0; k < 300; k++) begin
            if (done) begin
                got = result;
                break;
            end
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        int seen;
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 result in reset", result, 32'h0);
        check("R10 done in reset", {31'h0, done}, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            issue(VEC[v][100:69], VEC[v][68:37], VEC[v][36]);
            wait_done(got);
            check($sformatf("R%0d vector %0d", VEC[v][3:0], v), got, VEC[v][35:4]);
        end

        // R9: done lasts one cycle and result is then held
        issue(32'h40400000, 32'h3F800000, 1'b0);
        wait_done(got);
        check("R1 3+1", got, 32'h40800000);
        @(negedge clk);
        check("R9 done pulse width", {31'h0, done}, 32'h0);
        repeat (5) @(negedge clk);
        check("R9 result held", result, 32'h40800000);

        // R9: a start issued mid-operation is ignored
        issue(32'h3F800000, 32'h3F800000, 1'b0);
        opnd_a = 32'h40A00000;
        opnd_b = 32'h40A00000;
        sub_op = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        wait_done(got);
        check("R9 first operation kept", got, 32'h40000000);
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check("R9 no second completion", 32'(seen), 32'h0);
        check("R9 result after ignored start", result, 32'h40000000);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule